// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a hardware master for the two-wire Ethernet PHY management bus. Given a single start pulse, it generates the MDC clock and sends one complete frame on MDIO to read or write a 16-bit register in an external PHY. The 5-bit PHY address and the 5-bit register address come from the host side. MDIO is presented as three separate signals: a drive value, a drive enable and a sampled input. A pad or tri-state buffer outside the block merges them onto the shared wire.

Every frame opens with a long preamble of ones, 33 MDC cycles, so that PHYs that need a preamble after power-up or after a bus fault can resynchronise. On a read, the master releases the line for the turnaround and samples it there. If the line is still high, no PHY answered. The master then clocks a recovery burst with the line released, returns all ones as the read data and raises an error flag. That flag stays set until the host starts the next transaction.

The MDC frequency is the system clock divided by twice `MDC_HALF_DIV`. The default of 20 gives 2.5 MHz from a 100 MHz system clock.

Top module: `mdio_master`

## Requirements
- R1: A transaction accepted by `start` begins with 33 MDC cycles during which `mdio_oe`=1 and `mdio_o`=1 at every rising edge of MDC.
- R2: After the preamble, the master drives the start pattern 0 then 1, then a 2-bit opcode: 1,0 for a read (`rd_nwr`=1) and 0,1 for a write (`rd_nwr`=0). These are MDC rising edges 33 to 36, counted from 0.
- R3: After the opcode, the master drives the 5-bit PHY address and then the 5-bit register address, most significant bit first. These are MDC rising edges 37 to 46.
- R4: `mdio_o` and `mdio_oe` change only on the clock where MDC falls. They are constant throughout every MDC high half.
- R5: In a write, the master drives the turnaround as 1 then 0 on edges 47 and 48. It then drives the 16 data bits, most significant bit first, on edges 49 to 64. It then releases MDIO for one last MDC cycle, so a write is 66 MDC cycles long.
- R6: In a read, MDIO is released from edge 47 onward, and the line is sampled at the end of each MDC high half. If the turnaround sample on edge 47 is low, the master captures 16 data bits on edges 48 to 63, most significant bit first, into `rd_data`. It then gives one idle cycle, so a read is 65 MDC cycles long.
- R7: If the turnaround sample is high, the master runs 32 more MDC cycles with MDIO released, 80 cycles in total. It then ends with `rd_data`=16'hFFFF and `no_phy`=1.
- R8: One MDC period is 2*`MDC_HALF_DIV` system clocks, low half first. MDC is low whenever `busy` is low.
- R9: A `start` pulse while `busy` is high is ignored. The running frame is unchanged, and only one `done` is produced.
- R10: `done` is high for exactly one clock at the end of every transaction, in the first clock with `busy` low. `no_phy` keeps its value until the next accepted `start`, which clears it.
- R11: `mdio_oe` is 0 during reset and whenever `busy` is low. It is also 0 during the release cycles of R5, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-clock request to begin a transaction |
| rd_nwr | input | 1 | 1 selects a read, 0 a write; sampled with `start` |
| phy_addr | input | 5 | Target PHY address; sampled with `start` |
| reg_addr | input | 5 | Target register address; sampled with `start` |
| wr_data | input | 16 | Write data; sampled with `start` |
| rd_data | output | 16 | Read result, valid when `done` pulses after a read |
| busy | output | 1 | High while a transaction is running |
| done | output | 1 | One-clock pulse at the end of a transaction |
| no_phy | output | 1 | Set when a read found no PHY; cleared by the next start |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The bench runs writes and reads with address and data patterns chosen to catch reversed bit order and stuck bits. These include alternating bits, a single set MSB or LSB, all ones and all zeros. A read answered by the PHY model is compared against a read whose turnaround is left high. This shows whether the master really branches on the sampled turnaround bit, both in frame length and in the returned data. A second start during a frame shows whether mid-frame requests are truly dropped. Checking `no_phy` after the absent read, and again after the following start, tells a sticky flag apart from one that is cleared too early or never cleared.

// File: rtl/mdio_pkg.sv
// Package: shared constants and phase encoding for the MDIO master.
// Assumes a clause-22 frame: 2-bit start, 2-bit opcode, two 5-bit addresses.
package mdio_pkg;

    // Frame slot counts, in MDC cycles.
    localparam int PRE_SLOTS     = 33;
    localparam int SOF_BITS      = 2;
    localparam int OP_BITS       = 2;
    localparam int TA_BITS       = 2;
    localparam int RECOVER_SLOTS = 32;

    // Sequencer phases, one per stretch of the frame.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_CMD,
        PH_WEND,
        PH_RTA,
        PH_RDAT,
        PH_ABSENT,
        PH_RIDLE
    } phase_e;

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: MDC generator. While run is high it toggles mdc every HALF_DIV
// clocks, starting with a low half. It flags the last clock of each MDC
// cycle (end of the high half), which is when the sequencer advances.
// Assumes HALF_DIV >= 2. When run is low, mdc is held low.
module mdio_mdc_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] half_cnt;
    logic          mdc_q;
    logic          half_end;

    assign half_end = run && (half_cnt == CW'(HALF_DIV - 1));
    assign slot_end = half_end && mdc_q;
    assign mdc      = mdc_q;

    // Purpose: count system clocks in each half period and toggle MDC.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half_cnt <= '0;
            mdc_q    <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            mdc_q    <= ~mdc_q;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    // R8: MDC holds its level inside a half period.
    assert_mdc_half_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !half_end) |=> (mdc_q == $past(mdc_q)));

endmodule

// File: rtl/mdio_rx_shift.sv
// Module: read-data capture register. It shifts in one line sample per
// enable, MSB first. fill_ones loads all ones (the absent-PHY result).
// Assumes the two controls are never high together.
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         fill_ones,
    input  logic         bit_in,
    output logic [W-1:0] data
);
    // Purpose: capture serial read data or force the all-ones result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (fill_ones) begin
            data <= '1;
        end else if (shift_en) begin
            data <= {data[W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/mdio_seq.sv
// Module: frame sequencer. It latches a request, builds the outgoing bit
// string (start, opcode, addresses and, for writes, turnaround and data),
// and steps through the phases one MDC cycle at a time on slot_end.
// Assumes slot_end marks the clock where MDC falls, so drive changes made
// on it are set up during the low half.
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slot_end,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              no_phy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rx_shift,
    output logic              rx_fill
);
    localparam int RD_BITS = SOF_BITS + OP_BITS + 2 * ADDR_W;
    localparam int WR_BITS = RD_BITS + TA_BITS + DATA_W;
    localparam int CNT_W   = $clog2(PRE_SLOTS + 1);

    phase_e             phase;
    logic [CNT_W-1:0]   cnt;
    logic [WR_BITS-1:0] tx_sr;
    logic               rd_q;
    logic               last_slot;
    logic [WR_BITS-1:0] frame_word;

    assign frame_word = {2'b01, (rd_nwr ? 2'b10 : 2'b01), phy_addr, reg_addr,
                         2'b10, wr_data};
    assign last_slot  = slot_end && (cnt == '0);
    assign busy       = (phase != PH_IDLE);

    // Purpose: drive MDIO only in the preamble and command phases.
    always_comb begin
        mdio_oe = (phase == PH_PRE) || (phase == PH_CMD);
        mdio_o  = (phase == PH_PRE) ? 1'b1 :
                  (phase == PH_CMD) ? tx_sr[WR_BITS-1] : 1'b0;
    end

    assign rx_shift = slot_end && (phase == PH_RDAT);
    assign rx_fill  = slot_end && (phase == PH_RTA) && mdio_i;

    // Purpose: phase stepping, slot counting and command shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            tx_sr  <= '0;
            rd_q   <= 1'b0;
            done   <= 1'b0;
            no_phy <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase  <= PH_PRE;
                    cnt    <= CNT_W'(PRE_SLOTS - 1);
                    tx_sr  <= frame_word;
                    rd_q   <= rd_nwr;
                    no_phy <= 1'b0;
                end
            end else if (slot_end) begin
                if (cnt != '0) cnt <= cnt - 1'b1;
                case (phase)
                    PH_PRE: if (last_slot) begin
                        phase <= PH_CMD;
                        cnt   <= rd_q ? CNT_W'(RD_BITS - 1) : CNT_W'(WR_BITS - 1);
                    end
                    PH_CMD: begin
                        tx_sr <= {tx_sr[WR_BITS-2:0], 1'b0};
                        if (last_slot) begin
                            phase <= rd_q ? PH_RTA : PH_WEND;
                            cnt   <= '0;
                        end
                    end
                    PH_RTA: begin
                        phase <= mdio_i ? PH_ABSENT : PH_RDAT;
                        cnt   <= mdio_i ? CNT_W'(RECOVER_SLOTS - 1) : CNT_W'(DATA_W - 1);
                    end
                    PH_RDAT: if (last_slot) begin
                        phase <= PH_RIDLE;
                        cnt   <= '0;
                    end
                    PH_ABSENT: if (last_slot) begin
                        phase  <= PH_IDLE;
                        done   <= 1'b1;
                        no_phy <= 1'b1;
                    end
                    default: begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R2: the first bit after the preamble is the start bit 0, driven.
    assert_sof_first_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRE && last_slot) |=> (mdio_oe && !mdio_o));

    // R9: a start in the middle of a frame does not restart the preamble.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && phase != PH_IDLE && phase != PH_PRE) |=> (phase != PH_PRE));

endmodule

// File: rtl/mdio_master.sv
// Module: MDIO management master top. It joins the MDC generator, the frame
// sequencer and the read capture register. Assumes an external buffer
// merges mdio_o/mdio_oe/mdio_i onto the shared wire, with a pull-up.
module mdio_master #(
    parameter int MDC_HALF_DIV = 20,
    parameter int ADDR_W       = 5,
    parameter int DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              no_phy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic slot_end;
    logic rx_shift;
    logic rx_fill;

    mdio_mdc_gen #(.HALF_DIV(MDC_HALF_DIV)) mdc_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .slot_end (slot_end)
    );

    mdio_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_nwr   (rd_nwr),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .slot_end (slot_end),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .no_phy   (no_phy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rx_shift (rx_shift),
        .rx_fill  (rx_fill)
    );

    mdio_rx_shift #(.W(DATA_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (rx_shift),
        .fill_ones (rx_fill),
        .bit_in    (mdio_i),
        .data      (rd_data)
    );

    // R1: a frame opens with MDIO driven high.
    assert_preamble_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o));

    // R10: done lasts a single clock and comes with busy low.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: the error flag always comes with the all-ones result.
    assert_absent_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_phy |-> (rd_data == '1));

    // R11 and R8: no drive and MDC low while idle.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/mdio_master_tb_top.sv
// Scoreboard bench: a driver task queues the expected frame, and a monitor
// captures MDIO at each MDC rise, answers reads as a PHY model, and
// compares the captured frame on done.
module mdio_master_tb_top;
    localparam int HALF = 3;

    typedef struct {
        bit        rd;
        bit [4:0]  phy;
        bit [4:0]  rg;
        bit [15:0] wd;
        bit [15:0] rv;
        bit        ta_hi;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, no_phy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    txn_t exp_q[$];
    txn_t cur;
    bit   cap_oe[128];
    bit   cap_v[128];
    int   nr = 0;
    int   since = 0;
    int   per_bad = 0;
    int   stab_bad = 0;
    bit   prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0, prev_done = 1'b0;

    always #5 clk = ~clk;

    mdio_master #(.MDC_HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .no_phy(no_phy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected drive at MDC rise i, with a region id: 0 preamble, 1 sof/op,
    // 2 addresses, 3 write turnaround/data, 4 release.
    function automatic void exp_bit(input txn_t t, input int i,
                                    output bit eo, output bit ev, output int rid);
        eo = 1'b0; ev = 1'b0; rid = 4;
        if (i < 33) begin eo = 1; ev = 1; rid = 0; end
        else if (i == 33) begin eo = 1; ev = 0; rid = 1; end
        else if (i == 34) begin eo = 1; ev = 1; rid = 1; end
        else if (i == 35) begin eo = 1; ev = t.rd; rid = 1; end
        else if (i == 36) begin eo = 1; ev = !t.rd; rid = 1; end
        else if (i < 42) begin eo = 1; ev = t.phy[41 - i]; rid = 2; end
        else if (i < 47) begin eo = 1; ev = t.rg[46 - i]; rid = 2; end
        else if (!t.rd && i == 47) begin eo = 1; ev = 1; rid = 3; end
        else if (!t.rd && i == 48) begin eo = 1; ev = 0; rid = 3; end
        else if (!t.rd && i < 65) begin eo = 1; ev = t.wd[64 - i]; rid = 3; end
    endfunction

    // Monitor: capture, PHY model, timing checks and frame comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) stab_bad++;
            if (done && prev_done)
                chk(0, "R10", "done wider than one clock", 1, 0);
            if (mdc && !prev_mdc) begin
                if (nr > 0 && since != 2 * HALF) per_bad++;
                since = 1;
                if (nr < 128) begin
                    cap_oe[nr] = mdio_oe;
                    cap_v[nr]  = mdio_o;
                end
                if (cur.rd) begin
                    if (nr == 47) mdio_i = cur.ta_hi;
                    else if (nr >= 48 && nr < 64 && !cur.ta_hi) mdio_i = cur.rv[63 - nr];
                end
                nr++;
            end else begin
                since++;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "done with nothing queued", 1, 0);
                end else begin
                    txn_t t;
                    int   elen;
                    bit   bad[5];
                    int   fa[5], fe[5];
                    string rel;
                    t = exp_q.pop_front();
                    elen = !t.rd ? 66 : (t.ta_hi ? 80 : 65);
                    for (int k = 0; k < 5; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
                    for (int i = 0; i < elen && i < nr && i < 128; i++) begin
                        bit eo, ev;
                        int rid;
                        exp_bit(t, i, eo, ev, rid);
                        if (cap_oe[i] !== eo || (eo && cap_v[i] !== ev)) begin
                            if (!bad[rid]) begin
                                fa[rid] = {cap_oe[i], cap_v[i]};
                                fe[rid] = {eo, ev};
                            end
                            bad[rid] = 1;
                        end
                    end
                    rel = !t.rd ? "R11" : (t.ta_hi ? "R7" : "R6");
                    chk(!bad[0], "R1", "preamble {oe,val}", fa[0], fe[0]);
                    chk(!bad[1], "R2", "start/opcode {oe,val}", fa[1], fe[1]);
                    chk(!bad[2], "R3", "addresses {oe,val}", fa[2], fe[2]);
                    if (!t.rd) chk(!bad[3], "R5", "turnaround/data {oe,val}", fa[3], fe[3]);
                    chk(!bad[4], rel, "released cycles {oe,val}", fa[4], fe[4]);
                    chk(nr == elen, !t.rd ? "R5" : rel, "MDC cycles in frame", nr, elen);
                    chk(!busy, "R10", "busy at done", busy, 0);
                    if (t.rd) begin
                        chk(rd_data == (t.ta_hi ? 16'hFFFF : t.rv), rel, "rd_data",
                            rd_data, t.ta_hi ? 16'hFFFF : t.rv);
                        chk(no_phy == t.ta_hi, rel, "no_phy", no_phy, t.ta_hi);
                    end else begin
                        chk(no_phy == 0, "R10", "no_phy after write", no_phy, 0);
                    end
                end
                nr = 0;
                mdio_i = 1'b1;
            end
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_done = done;
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_txn(input bit rd, input bit [4:0] phy, input bit [4:0] rg,
                           input bit [15:0] wd, input bit [15:0] rv,
                           input bit ta_hi, input bit poke);
        txn_t t;
        t.rd = rd; t.phy = phy; t.rg = rg; t.wd = wd; t.rv = rv; t.ta_hi = ta_hi;
        @(negedge clk);
        cur = t;
        exp_q.push_back(t);
        start = 1'b1; rd_nwr = rd; phy_addr = phy; reg_addr = rg; wr_data = wd;
        @(negedge clk);
        start = 1'b0;
        rd_nwr = ~rd; phy_addr = ~phy; reg_addr = ~rg; wr_data = ~wd;
        if (poke) begin
            wait_clks(150);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        wait_clks(3);
        chk(!mdc && !mdio_oe, "R8", "mdc/oe idle after done {mdc,oe}",
            {mdc, mdio_oe}, 0);
    endtask

    // Watchdog.
    initial begin
        while (cycles < 200000 && !finished) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        cur = '{rd: 0, phy: 0, rg: 0, wd: 0, rv: 0, ta_hi: 0};
        wait_clks(4);
        chk(!busy && !done && !mdio_oe && !mdc, "R11", "reset {busy,done,oe,mdc}",
            {busy, done, mdio_oe, mdc}, 0);
        rst_n = 1'b1;
        wait_clks(3);
        chk(!busy && !mdio_oe && !mdc, "R8", "idle after reset {busy,oe,mdc}",
            {busy, mdio_oe, mdc}, 0);

        run_txn(0, 5'h11, 5'h0A, 16'hA5C3, 16'h0, 0, 0);
        run_txn(1, 5'h03, 5'h1F, 16'h0, 16'h8001, 0, 0);
        run_txn(1, 5'h1E, 5'h01, 16'h0, 16'h1234, 1, 0);
        wait_clks(10);
        chk(no_phy == 1'b1, "R10", "no_phy held while idle", no_phy, 1);
        chk(rd_data == 16'hFFFF, "R7", "rd_data held while idle", rd_data, 16'hFFFF);
        @(negedge clk);
        exp_q.push_back('{rd: 0, phy: 5'h1F, rg: 5'h00, wd: 16'h0000, rv: 0, ta_hi: 0});
        cur = exp_q[0];
        start = 1'b1; rd_nwr = 1'b0; phy_addr = 5'h1F; reg_addr = 5'h00; wr_data = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(no_phy == 1'b0, "R10", "no_phy cleared by start", no_phy, 0);
        while (!done) @(negedge clk);
        wait_clks(3);

        run_txn(0, 5'h00, 5'h15, 16'hFFFF, 16'h0, 0, 1);
        run_txn(1, 5'h10, 5'h08, 16'h0, 16'h7FFE, 0, 0);
        wait_clks(5);
        chk(exp_q.size() == 0, "R9", "frames left unmatched", exp_q.size(), 0);
        chk(per_bad == 0, "R8", "MDC periods off", per_bad, 0);
        chk(stab_bad == 0, "R4", "drive changes during MDC high", stab_bad, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule